// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog timer that sits on a simple word-wide register bus with an address, a write strobe, write data and combinational read data. Inside it is a 32-bit down-counter. Software picks a timeout as a power-of-two exponent and then sets the enable bit. After that, software must keep writing a fixed key word to a restart register before the counter runs out. Once enabled, the watchdog cannot be turned off by software.

There are two expiry responses. In the direct mode, expiry raises a system reset request. That request is a registered pulse of fixed length, after which the counter stays at zero until the block itself is reset. In the two-stage mode, the first expiry raises an interrupt and re-arms the counter. A second expiry with no valid restart in between then requests the reset. Two range fields are kept: one sets the first period after enabling, and the other sets every later period.

Top module: `keywd_timer`

## Requirements
- R1: After reset, the control word (offset 0x00) and the range word (offset 0x04) read 0, and `irq_o` and `sys_rst_req_o` are low.
- R2: In the control word, bit 0 is the enable bit and bit 1 is the mode bit. In the range word, bits [3:0] hold the running range and bits [7:4] hold the initial range, and all higher bits read 0. The restart offset 0x0C and every unused offset read 0.
- R3: A range value i selects a period P = 2^(RANGE_BASE+i) cycles, and RANGE_BASE defaults to 16. When enable goes from 0 to 1, the counter loads P from the initial range. The first expiry response becomes visible P+1 clock edges after the edge that registers the enabling write.
- R4: Writing the word 0x76 to offset 0x0C while the watchdog is enabled reloads the counter with the running-range period. The next expiry response then appears P+1 edges after that write.
- R5: A write to offset 0x0C with any other value, or a write of 0x76 to any other offset, leaves the count and the expiry time unchanged.
- R6: Once the enable bit is set, writing 0 to it has no effect. Only the block reset clears it.
- R7: In mode 0 (bit 1 = 0), expiry raises `sys_rst_req_o` for exactly RST_CYCLES cycles (default 8). After that pulse, no further interrupt or reset is produced until the block is reset, and restart writes are ignored.
- R8: In mode 1, the first expiry sets `irq_o` without a reset and reloads the running period. A second expiry while `irq_o` is still set raises the reset request.
- R9: A valid restart clears a pending `irq_o` on the next edge. The next expiry after that raises the interrupt again, not the reset.
- R10: While the watchdog is disabled, the counter holds its value, no interrupt or reset is produced, and restart writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| irq_o | output | 1 | First-stage expiry interrupt (mode 1) |
| sys_rst_req_o | output | 1 | System reset request pulse |

## Verification
The assertions assume that `bus_we` and `bus_wdata` are stable for one full cycle around each rising edge. They also assume that a start of counting happens only through the enable bit, and that the block reset is the only way out of the reset-pulse and dead states. The bench drives every input on the falling edge and holds each write for exactly one cycle. It applies a block reset between scenarios, because after a reset request the block stays dead until reset. The bench uses RANGE_BASE = 4, so that periods are short enough to measure exactly in cycles. The exponent-to-period relation under test is the same one used at the default.

// File: rtl/keywd_pkg.sv
package keywd_pkg;
    localparam logic [7:0]  OFS_CTRL  = 8'h00;
    localparam logic [7:0]  OFS_RANGE = 8'h04;
    localparam logic [7:0]  OFS_KICK  = 8'h0C;
    localparam logic [31:0] KICK_KEY  = 32'h0000_0076;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_PULSE = 2'd1,
        PH_DEAD  = 2'd2
    } phase_t;
endpackage

// File: rtl/keywd_regs.sv
module keywd_regs
    import keywd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int RNG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              en_o,
    output logic              mode_o,
    output logic [RNG_W-1:0]  run_rng_o,
    output logic [RNG_W-1:0]  init_rng_o,
    output logic              start_o,
    output logic              kick_o
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RANGE = ADDR_W'(OFS_RANGE);
    localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_KICK);

    typedef struct packed {
        logic             en;
        logic             mode;
        logic [RNG_W-1:0] run_rng;
        logic [RNG_W-1:0] init_rng;
    } regs_t;

    regs_t r_d, r_q;
    logic  start_d, kick_d;

    always_comb begin
        r_d     = r_q;
        start_d = 1'b0;
        kick_d  = 1'b0;
        if (we_i) begin
            case (addr_i)
                A_CTRL: begin
                    r_d.en   = r_q.en | wdata_i[0];
                    r_d.mode = wdata_i[1];
                    start_d  = wdata_i[0] & ~r_q.en;
                end
                A_RANGE: begin
                    r_d.run_rng  = wdata_i[RNG_W-1:0];
                    r_d.init_rng = wdata_i[2*RNG_W-1:RNG_W];
                end
                A_KICK: kick_d = (wdata_i == DATA_W'(KICK_KEY));
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr_i)
            A_CTRL:  rdata_o = {{(DATA_W-2){1'b0}}, r_q.mode, r_q.en};
            A_RANGE: rdata_o = {{(DATA_W-2*RNG_W){1'b0}}, r_q.init_rng, r_q.run_rng};
            default: rdata_o = '0;
        endcase
    end

    assign en_o       = r_q.en;
    assign mode_o     = r_q.mode;
    assign run_rng_o  = r_q.run_rng;
    assign init_rng_o = r_q.init_rng;
    assign start_o    = start_d;
    assign kick_o     = kick_d;

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.en |=> r_q.en); // R6

    AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        start_d |-> !r_q.en); // R3
endmodule

// File: rtl/keywd_count.sv
module keywd_count
    import keywd_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int RNG_W      = 4,
    parameter int RANGE_BASE = 16,
    parameter int RST_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             mode_i,
    input  logic [RNG_W-1:0] run_rng_i,
    input  logic [RNG_W-1:0] init_rng_i,
    input  logic             start_i,
    input  logic             kick_i,
    output logic             irq_o,
    output logic             rst_req_o
);
    localparam int PC_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        phase_t           phase;
        logic [PC_W-1:0]  pcnt;
    } cstate_t;

    cstate_t s_d, s_q;
    logic [CNT_W-1:0] run_p, init_p;

    function automatic logic [CNT_W-1:0] period_of(input logic [RNG_W-1:0] rng);
        return {{(CNT_W-1){1'b0}}, 1'b1} << (RANGE_BASE + 32'(rng));
    endfunction

    assign run_p  = period_of(run_rng_i);
    assign init_p = period_of(init_rng_i);

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_RUN: begin
                if (start_i) begin
                    s_d.cnt = init_p;
                end else if (en_i) begin
                    if (kick_i) begin
                        s_d.cnt = run_p;
                        s_d.irq = 1'b0;
                    end else if (s_q.cnt == '0) begin
                        if (mode_i && !s_q.irq) begin
                            s_d.irq = 1'b1;
                            s_d.cnt = run_p;
                        end else begin
                            s_d.phase = PH_PULSE;
                            s_d.pcnt  = PC_W'(RST_CYCLES - 1);
                        end
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
            end
            PH_PULSE: begin
                if (s_q.pcnt == '0) s_d.phase = PH_DEAD;
                else                s_d.pcnt  = s_q.pcnt - 1'b1;
            end
            PH_DEAD: ;
            default: s_d.phase = PH_DEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, irq: 1'b0, phase: PH_RUN, pcnt: '0};
        else        s_q <= s_d;
    end

    assign irq_o     = s_q.irq;
    assign rst_req_o = (s_q.phase == PH_PULSE);

    AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && kick_i && s_q.phase == PH_RUN) |=> (s_q.cnt == $past(run_p) && !s_q.irq)); // R4

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !start_i) |=> $stable(s_q.cnt)); // R10

    AST_NO_RST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o || irq_o) |-> en_i); // R10

    AST_DEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_RUN) |-> (s_q.cnt == '0)); // R7

    AST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.irq) |-> $past(mode_i)); // R8
endmodule

// File: rtl/keywd_timer.sv
module keywd_timer #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 32,
    parameter int RNG_W      = 4,
    parameter int RANGE_BASE = 16,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_req_o
);
    logic             en, mode, start, kick;
    logic [RNG_W-1:0] run_rng, init_rng;

    keywd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RNG_W(RNG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .we_i       (bus_we),
        .wdata_i    (bus_wdata),
        .rdata_o    (bus_rdata),
        .en_o       (en),
        .mode_o     (mode),
        .run_rng_o  (run_rng),
        .init_rng_o (init_rng),
        .start_o    (start),
        .kick_o     (kick)
    );

    keywd_count #(.CNT_W(CNT_W), .RNG_W(RNG_W), .RANGE_BASE(RANGE_BASE),
                  .RST_CYCLES(RST_CYCLES)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .mode_i     (mode),
        .run_rng_i  (run_rng),
        .init_rng_i (init_rng),
        .start_i    (start),
        .kick_i     (kick),
        .irq_o      (irq_o),
        .rst_req_o  (sys_rst_req_o)
    );

    AST_PULSE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_req_o) |-> $past(en)); // R7
endmodule

// File: tb/sim_keywd_timer.sv
module sim_keywd_timer;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 4;
    localparam int RSTC       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_req_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    keywd_timer #(.RANGE_BASE(BASE), .RST_CYCLES(RSTC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    // latency in edges from t0 until the signal is seen high; -1 if never
    task automatic wait_rst(input int t0, output int lat);
        lat = -1;
        for (int i = 0; i < 5000; i++) begin
            if (sys_rst_req_o) begin lat = cyc - t0; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_irq(input int t0, output int lat);
        lat = -1;
        for (int i = 0; i < 5000; i++) begin
            if (irq_o) begin lat = cyc - t0; break; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        int v;
        do_reset();
        rd(8'h00, v); chk("R1 ctrl", v, 0);
        rd(8'h04, v); chk("R1 range", v, 0);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 rst_req", int'(sys_rst_req_o), 0);
    endtask

    task automatic t_readback();
        int v;
        do_reset();
        wr(8'h04, 32'hFFFF_FF5A);
        rd(8'h04, v); chk("R2 range fields", v, 32'h5A);
        wr(8'h00, 32'h0000_0002);
        rd(8'h00, v); chk("R2 mode bit", v, 2);
        rd(8'h0C, v); chk("R2 restart reads zero", v, 0);
        rd(8'h08, v); chk("R2 unused reads zero", v, 0);
        rd(8'h10, v); chk("R2 unused reads zero", v, 0);
    endtask

    task automatic t_disabled();
        int t0, lat;
        do_reset();
        wr(8'h04, 32'h0000_0030);        // init=3, run=0
        wr(8'h0C, 32'h76);               // kick while off
        repeat (100) @(negedge clk);
        chk("R10 no irq while off", int'(irq_o), 0);
        chk("R10 no rst while off", int'(sys_rst_req_o), 0);
        wr(8'h00, 32'h1);
        t0 = cyc;
        wait_rst(t0, lat);
        chk("R3 init range 3 latency", lat, (1 << (BASE + 3)) + 1);
    endtask

    task automatic t_mode0_pulse();
        int t0, lat, len;
        do_reset();
        wr(8'h04, 32'h0000_0010);        // init=1, run=0
        wr(8'h00, 32'h1);
        t0 = cyc;
        wait_rst(t0, lat);
        chk("R3 init range 1 latency", lat, (1 << (BASE + 1)) + 1);
        len = 0;
        while (sys_rst_req_o && len < 100) begin len++; @(negedge clk); end
        chk("R7 pulse length", len, RSTC);
        wr(8'h0C, 32'h76);
        repeat (200) @(negedge clk);
        chk("R7 no further rst", int'(sys_rst_req_o), 0);
        chk("R7 no irq after", int'(irq_o), 0);
    endtask

    task automatic t_kick();
        int t1, lat;
        do_reset();
        wr(8'h04, 32'h0000_0020);        // init=2, run=0
        wr(8'h00, 32'h1);
        repeat (40) @(negedge clk);
        wr(8'h0C, 32'h76);
        t1 = cyc;
        wait_rst(t1, lat);
        chk("R4 run period after key", lat, (1 << BASE) + 1);
    endtask

    task automatic t_wrong_key();
        int t0, lat;
        do_reset();
        wr(8'h04, 32'h0000_0010);        // init=1, run=0
        wr(8'h00, 32'h1);
        t0 = cyc;
        repeat (5) @(negedge clk);
        wr(8'h0C, 32'h75);
        wr(8'h08, 32'h76);
        wr(8'h0C, 32'h176);
        wait_rst(t0, lat);
        chk("R5 wrong keys ignored", lat, (1 << (BASE + 1)) + 1);
    endtask

    task automatic t_sticky();
        int t0, lat, v;
        do_reset();
        wr(8'h04, 32'h0000_0010);
        wr(8'h00, 32'h1);
        t0 = cyc;
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R6 enable stays set", v & 1, 1);
        wait_rst(t0, lat);
        chk("R6 still expires", lat, (1 << (BASE + 1)) + 1);
    endtask

    task automatic t_mode1();
        int t0, t1, lat;
        do_reset();
        wr(8'h04, 32'h0000_0010);        // init=1, run=0
        wr(8'h00, 32'h3);
        t0 = cyc;
        wait_irq(t0, lat);
        chk("R8 first expiry irq", lat, (1 << (BASE + 1)) + 1);
        chk("R8 no rst at first expiry", int'(sys_rst_req_o), 0);
        t1 = cyc;
        wait_rst(t1, lat);
        chk("R8 second expiry rst", lat, (1 << BASE) + 1);
    endtask

    task automatic t_mode1_clear();
        int t0, t1, lat;
        do_reset();
        wr(8'h04, 32'h0000_0010);
        wr(8'h00, 32'h3);
        t0 = cyc;
        wait_irq(t0, lat);
        wr(8'h0C, 32'h76);
        t1 = cyc;
        chk("R9 irq cleared by key", int'(irq_o), 0);
        wait_irq(t1, lat);
        chk("R9 irq again after clear", lat, (1 << BASE) + 1);
        chk("R9 no rst after clear", int'(sys_rst_req_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_readback();
        t_disabled();
        t_mode0_pulse();
        t_kick();
        t_wrong_key();
        t_sticky();
        t_mode1();
        t_mode1_clear();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule